// File: doc/BRIEF.md
# Sub-Audio Tone Frequency Meter

This block measures the frequency of a received sub-audio tone that has already been squared, noise filtered and frequency doubled. Once enabled, it waits for a rising edge of the doubled tone and opens a fixed window of 511 measuring-clock ticks. During the window it counts complete doubled-tone cycles (N). It also counts the leftover ticks (R) between the last complete cycle and the close of the window. The pair is reported as one 16-bit word. With a 4 MHz system reference, the measuring clock runs at 4166.6 Hz and the window lasts 122.64 ms. The input frequency then follows from f = N·fclk / (1920·(511−R)).

The measuring clock reaches the block as a one-cycle enable strobe on the system clock. When a window closes, the block pulses a done output, raises a sticky done flag and loads the new result word. It then re-arms on the next rising edge, so it measures continuously for as long as it stays enabled. A status-read strobe clears the flag. Dropping the enable acts as power-save: it aborts any open window and clears the flag, but keeps the last result. All pins are plain control and status signals. No stream carries data into or out of the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `tone_freq_meter`

## Requirements
- R1: While reset is held and just after it is released, the result word, the done pulse and the done flag are all zero.
- R2: A window opens at the first rising edge of the doubled tone sampled while enabled. The window closes on the 511th measuring tick sampled after that edge; a tick in the same cycle as the opening edge does not count.
- R3: Bits 13:8 of the result hold N, the number of rising edges after the opening edge, up to and including the closing cycle.
- R4: Bits 5:0 of the result hold R, the number of measuring ticks after the last edge counted in N (or after the opening edge if N is 0), up to and including the closing tick. An edge in the same cycle as a tick is taken to follow that tick.
- R5: N and R each saturate at 63 instead of wrapping.
- R6: Result bits 15:14 and 7:6 always read zero.
- R7: In the cycle after the closing tick, the result is updated, the done pulse is high for exactly one cycle, and the done flag is set. The result changes at no other time.
- R8: A status-read strobe clears the done flag in the next cycle and leaves the result unchanged. If a window closes in the same cycle as the strobe, the flag ends up set.
- R9: While the enable is low, the next cycle shows the done flag clear. Any open window is discarded, and measuring restarts from the first rising edge after the enable returns. The result is kept.
- R10: After a window closes, with the enable still high, the next window opens at the first rising edge after the closing cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_tick | input | 1 | One-cycle strobe for each measuring-clock tick |
| tone_x2 | input | 1 | Squared tone at twice the received frequency |
| meas_en | input | 1 | Enable; low means power-save |
| stat_clr | input | 1 | Status-read strobe that clears the done flag |
| result | output | 16 | N in bits 13:8, R in bits 5:0, other bits zero |
| done_pulse | output | 1 | One-cycle pulse when a window closes |
| done_flag | output | 1 | Sticky measurement-complete flag |

## Verification
The bench drives tone periods that place the last edge at varied distances from the window end, so a design with an off-by-one in R or a window one tick long or short gives a wrong R or a done pulse in the wrong cycle. Very fast and very slow tones check that both fields saturate at 63; a counter that wraps instead would report a small in-band value. A mid-window power-save and a back-to-back second window check the restart rules: a design that kept partial counts, or re-armed on a stale edge, would close early or report wrong N and R. A status-read strobe in the same cycle as a window close checks that the flag stays set, where a design that let the clear win would lose a completion.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  typedef enum logic {
    ST_ARM  = 1'b0,
    ST_MEAS = 1'b1
  } tfm_state_e;
endpackage

// File: rtl/tfm_rise_det.sv
module tfm_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/tfm_sat_ctr.sv
module tfm_sat_ctr #(
  parameter int W   = 9,
  parameter int MAX = 511
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = W'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)            cnt_o <= '0;
    else if (inc_i && cnt_o != MAXV) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tfm_result_pack.sv
module tfm_result_pack #(
  parameter int FIELD_W = 6,
  parameter int N_LSB   = 8,
  parameter int R_LSB   = 0,
  parameter int RES_W   = 16
) (
  input  logic [FIELD_W-1:0] n_i,
  input  logic [FIELD_W-1:0] r_i,
  output logic [RES_W-1:0]   word_o
);
  always_comb begin
    word_o = '0;
    word_o[N_LSB +: FIELD_W] = n_i;
    word_o[R_LSB +: FIELD_W] = r_i;
  end
endmodule

// File: rtl/tone_freq_meter.sv
module tone_freq_meter #(
  parameter int WIN_TICKS = 511,
  parameter int FIELD_W   = 6,
  parameter int N_LSB     = 8,
  parameter int R_LSB     = 0,
  parameter int RES_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_tick,
  input  logic             tone_x2,
  input  logic             meas_en,
  input  logic             stat_clr,
  output logic [RES_W-1:0] result,
  output logic             done_pulse,
  output logic             done_flag
);
  import tfm_pkg::*;

  localparam int TICK_W = $clog2(WIN_TICKS + 1);
  localparam int FMAX   = (1 << FIELD_W) - 1;
  localparam logic [TICK_W-1:0]  LAST_IDX = TICK_W'(WIN_TICKS - 1);
  localparam logic [FIELD_W-1:0] FMAXV    = FIELD_W'(FMAX);
  localparam logic [TICK_W:0]    FMAX_W   = (TICK_W+1)'(FMAX);

  tfm_state_e state_q;
  logic rise, start, in_win, win_last;
  logic [TICK_W-1:0]  win_cnt, since_cnt;
  logic [FIELD_W-1:0] edge_cnt, n_fin, r_fin;
  logic [TICK_W:0]    r_ext;
  logic [RES_W-1:0]   packed_word;

  tfm_rise_det u_rise (
    .clk(clk), .rst_n(rst_n), .sig_i(tone_x2), .rise_o(rise)
  );

  assign start    = (state_q == ST_ARM) && meas_en && rise;
  assign in_win   = (state_q == ST_MEAS) && meas_en;
  assign win_last = in_win && meas_tick && (win_cnt == LAST_IDX);

  // window length counter
  tfm_sat_ctr #(.W(TICK_W), .MAX(WIN_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n),
    .clr_i(start || !meas_en || win_last),
    .inc_i(in_win && meas_tick),
    .cnt_o(win_cnt)
  );

  // complete doubled-tone cycles
  tfm_sat_ctr #(.W(FIELD_W), .MAX(FMAX)) u_edges (
    .clk(clk), .rst_n(rst_n),
    .clr_i(start || !meas_en),
    .inc_i(in_win && rise),
    .cnt_o(edge_cnt)
  );

  // ticks since the last counted edge; an edge in a tick cycle follows the tick
  tfm_sat_ctr #(.W(TICK_W), .MAX(WIN_TICKS)) u_since (
    .clk(clk), .rst_n(rst_n),
    .clr_i(start || !meas_en || (in_win && rise)),
    .inc_i(in_win && meas_tick),
    .cnt_o(since_cnt)
  );

  always_comb begin
    if (edge_cnt == FMAXV) n_fin = FMAXV;
    else                   n_fin = edge_cnt + FIELD_W'(rise);
    r_ext = {1'b0, since_cnt} + 1'b1;
    if (rise)                 r_fin = '0;
    else if (r_ext > FMAX_W)  r_fin = FMAXV;
    else                      r_fin = r_ext[FIELD_W-1:0];
  end

  tfm_result_pack #(
    .FIELD_W(FIELD_W), .N_LSB(N_LSB), .R_LSB(R_LSB), .RES_W(RES_W)
  ) u_pack (
    .n_i(n_fin), .r_i(r_fin), .word_o(packed_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_ARM;
      result     <= '0;
      done_pulse <= 1'b0;
      done_flag  <= 1'b0;
    end else begin
      done_pulse <= win_last;
      if (win_last) result <= packed_word;

      if (!meas_en)      state_q <= ST_ARM;
      else if (start)    state_q <= ST_MEAS;
      else if (win_last) state_q <= ST_ARM;

      if (!meas_en)      done_flag <= 1'b0;
      else if (win_last) done_flag <= 1'b1;
      else if (stat_clr) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tfm_checker.sv
module tfm_checker #(
  parameter int FIELD_W = 6,
  parameter int N_LSB   = 8,
  parameter int R_LSB   = 0,
  parameter int RES_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_tick,
  input logic             meas_en,
  input logic             stat_clr,
  input logic [RES_W-1:0] result,
  input logic             done_pulse,
  input logic             done_flag
);
  localparam logic [RES_W-1:0] USED =
    ((RES_W)'((1 << FIELD_W) - 1) << N_LSB) | ((RES_W)'((1 << FIELD_W) - 1) << R_LSB);

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (result & ~USED) == '0);

  p_flag_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done_flag);

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done_pulse);

  p_close_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(meas_tick && meas_en));

  p_clear_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && meas_en) |=> (!done_flag || done_pulse));

  p_powersave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> (!done_flag && !done_pulse));
endmodule

bind tone_freq_meter tfm_checker #(
  .FIELD_W(FIELD_W), .N_LSB(N_LSB), .R_LSB(R_LSB), .RES_W(RES_W)
) u_tfm_checker (
  .clk(clk), .rst_n(rst_n), .meas_tick(meas_tick), .meas_en(meas_en),
  .stat_clr(stat_clr), .result(result), .done_pulse(done_pulse),
  .done_flag(done_flag)
);

// File: tb/test_tone_freq_meter.sv
module test_tone_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WIN        = 511;
  localparam int CYC_LIMIT  = 190000;

  logic clk = 1'b0;
  logic rst_n, meas_tick, tone_x2, meas_en, stat_clr;
  logic [15:0] result;
  logic done_pulse, done_flag;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [15:0] last_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_freq_meter i_tone_freq_meter (
    .clk(clk), .rst_n(rst_n), .meas_tick(meas_tick), .tone_x2(tone_x2),
    .meas_en(meas_en), .stat_clr(stat_clr), .result(result),
    .done_pulse(done_pulse), .done_flag(done_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat63(input int v);
    return (v > 63) ? 63 : v;
  endfunction

  // expected window from an enable start cycle s, tone edges at ph + k*p
  function automatic void expect_win(input int s, input int ph, input int p,
                                     output int tend, output int n, output int r);
    int e0, ft, le;
    e0   = (s <= ph) ? ph : ph + ((s - ph + p - 1) / p) * p;
    ft   = (e0 / TICK_DIV + 1) * TICK_DIV;
    tend = ft + (WIN - 1) * TICK_DIV;
    n    = (tend - 1 - e0) / p;
    le   = e0 + n * p;
    r    = tend / TICK_DIV - le / TICK_DIV;
  endfunction

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic check_word(input int n, input int r, input int p);
    chk("R3 N field", int'(result[13:8]), sat63(n));
    chk("R4 R field", int'(result[5:0]), sat63(r));
    chk("R6 reserved bits", int'({result[15:14], result[7:6]}), 0);
    if (n > 63 || r > 63) chk("R5 saturation seen", int'(result[13:8] == 6'd63 || result[5:0] == 6'd63), 1);
    if (n >= 16 && n <= 61 && r <= 31) begin
      int d;
      d = n * p - (WIN - r) * TICK_DIV;
      if (d < 0) d = -d;
      chk("R3 R4 frequency relation", int'(d < TICK_DIV), 1);
    end
  endtask

  // one measurement run: two consecutive windows
  task automatic run_meas(input int p, input int abort_at, input bit clr_at_end, input bit clr_mid);
    int ph, s, t1, n1, r1, t2, n2, r2, dones, guard, ab;
    logic [15:0] first_res;
    meas_en = 1'b0; tone_x2 = 1'b0; stat_clr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      meas_tick = (cyc % TICK_DIV) == 0;
      step();
    end
    chk("R9 flag clear in power-save", int'(done_flag), 0);
    chk("R9 result retained", int'(result), int'(last_res));
    s  = cyc;
    ph = (cyc + 7) | 1;
    ab = (abort_at > 0) ? s + abort_at : -10;
    expect_win(s, ph, p, t1, n1, r1);
    expect_win(t1 + 1, ph, p, t2, n2, r2);
    dones = 0; guard = 0; first_res = '0;
    while (dones < 2 && guard < 20000 && cyc < CYC_LIMIT) begin
      // observe outputs of posedge cyc-1
      if (done_pulse) begin
        if (dones == 0) begin
          chk("R2 R7 close cycle", cyc - 1, t1);
          chk("R7 flag set", int'(done_flag), 1);
          check_word(n1, r1, p);
          first_res = result;
        end else begin
          chk("R10 second close cycle", cyc - 1, t2);
          chk("R10 flag set", int'(done_flag), 1);
          check_word(n2, r2, p);
        end
        last_res = result;
        dones++;
      end
      if (clr_mid && dones == 1 && cyc == t1 + 6) begin
        chk("R8 flag cleared by read", int'(done_flag), 0);
        chk("R8 result unchanged", int'(result), int'(first_res));
      end
      // drive inputs for posedge cyc
      meas_en   = !(cyc == ab || cyc == ab + 1);
      if (cyc == ab + 2) begin
        expect_win(cyc, ph, p, t1, n1, r1);
        expect_win(t1 + 1, ph, p, t2, n2, r2);
      end
      meas_tick = (cyc % TICK_DIV) == 0;
      tone_x2   = (cyc >= ph) && (((cyc - ph) % p) < p / 2);
      stat_clr  = (clr_at_end && cyc == t1) || (clr_mid && cyc == t1 + 4);
      step();
      guard++;
    end
    if (dones < 2) begin
      nerr++; nchk++;
      $display("FAIL R2 watchdog actual %0d expected %0d", dones, 2);
    end
    stat_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; meas_tick = 1'b0; tone_x2 = 1'b0; meas_en = 1'b0; stat_clr = 1'b0;
    void'($urandom(32'h0805_5eed));
    @(negedge clk);
    for (int i = 0; i < 4; i++) step();
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset flag", int'(done_flag), 0);
    rst_n = 1'b1;
    step();
    chk("R1 result after release", int'(result), 0);
    chk("R1 pulse after release", int'(done_pulse), 0);
    chk("R1 flag after release", int'(done_flag), 0);

    run_meas(84, 0, 1'b0, 1'b0);    // mid band
    run_meas(34, 0, 1'b0, 1'b1);    // near top of band, R8 mid clear
    run_meas(20, 0, 1'b0, 1'b0);    // R5 N saturation
    run_meas(3000, 0, 1'b0, 1'b0);  // R5 R saturation, N = 0
    run_meas(84, 600, 1'b0, 1'b0);  // R9 abort mid-window
    run_meas(100, 0, 1'b1, 1'b0);   // R8 clear coincides with close
    run_meas(66, 0, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) begin
      int p;
      p = 24 + 2 * int'($urandom % 190);
      run_meas(p, (k % 3 == 0) ? 300 + int'($urandom % 900) : 0, k[0], k[1]);
    end

    meas_en = 1'b0;
    step();
    chk("R9 flag clear at end", int'(done_flag), 0);
    if (cyc >= CYC_LIMIT) begin
      nerr++; nchk++;
      $display("FAIL R2 cycle limit actual %0d expected %0d", cyc, CYC_LIMIT);
    end
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule